// File: doc/BRIEF.md
# NAND Page ECC Parity Generator

This block builds a Hamming-style check code over a stream of bytes moving between the host and a NAND flash device, for a block of at most 512 bytes. Software arms it with a start write, which wipes the previous code and raises the busy flag. While busy, and only while the active chip select is set up for NAND operation, every byte strobed on the data interface is folded into two kinds of parity. Column parities are taken over bit positions within a byte. Row parities are even/odd pairs chosen by the bits of the byte's position in the block.

When the transfer is over, software reads the result register. The read drops the busy flag and leaves the code unchanged, so later bus traffic cannot disturb it. For blocks shorter than 512 bytes, software ignores the upper row pairs. Error location and correction are left to software.

Top module: `pageEccGen`

## Requirements
- R1: After reset, `busy` is 0 and `eccResult` is all zeros.
- R2: A cycle with `startWr` high makes `eccResult` zero and `busy` 1 from the next cycle on.
- R3: A cycle with `resultRd` high and `startWr` low makes `busy` 0 from the next cycle on. `eccResult` keeps its value.
- R4: Column pair j (j = 0, 1, 2) is the XOR, over all folded bytes, of the data bits whose bit index has bit j equal to 0 (even) or 1 (odd). For example, pair 0 uses bits {0,2,4,6} and {1,3,5,7}.
- R5: The n-th folded byte after a start has byte index n-1, counting from 0. Row pair k (k = 0..8) is the XOR of the full parity of each folded byte. Bytes whose index bit k is 0 go into the even bit, and bytes whose index bit k is 1 go into the odd bit.
- R6: Bit layout of `eccResult`: bits [2:0] are the even column pairs 0..2, bits [11:3] are the even row pairs 0..8, bits [14:12] are the odd column pairs 0..2, and bits [23:15] are the odd row pairs 0..8.
- R7: A byte strobe has no effect on `eccResult` when `busy` is 0 or when `nandMode` is 0.
- R8: `startWr` takes priority. A byte strobe or a result read in the same cycle as `startWr` is not folded in and does not clear `busy`.
- R9: The byte index stops advancing after 512 bytes. The 513th and every later byte are still folded in, with byte index 0.
- R10: After at most 256 bytes, bit 23 (odd row pair 8) is 0. After at most 128 bytes, bits 23 and 22 are both 0.
- R11: Every even/odd pair has the same XOR of its two bits, and that value equals the parity of all folded data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nandMode | input | 1 | Chip select of the current transfer is set up for NAND operation |
| startWr | input | 1 | One-cycle pulse: software wrote 1 to the start bit |
| resultRd | input | 1 | One-cycle pulse: software read the result register |
| byteValid | input | 1 | A byte is transferred this cycle |
| byteData | input | 8 | Transferred byte |
| busy | output | 1 | Calculation active |
| eccResult | output | 24 | Packed parity result |

## Verification
The bench builds the block with its default widths: 8-bit data and a 512-byte limit, which gives 9 row pairs and a 24-bit result. With these values the saturation of the byte index is reached after 512 strobes, inside a short run, so the behaviour of bytes past the limit can be tried directly. Blocks of 128 and 256 bytes show the upper odd row bits staying at zero. Single-byte cases pin down each column mask and the bit layout against hand-computed constants.

// File: rtl/eccPkg.sv
package eccPkg;
  // strobes from the control to the parity datapath
  typedef struct packed {
    logic clearAcc;  // wipe all parity registers
    logic foldByte;  // XOR the present byte into the parities
  } eccStrobeT;
endpackage

// File: rtl/eccCtrl.sv
module eccCtrl
  import eccPkg::*;
#(
  parameter int MAX_BYTES = 512,
  parameter int ROW_BITS  = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                nandMode,
  input  logic                startWr,
  input  logic                resultRd,
  input  logic                byteValid,
  output eccStrobeT           strobe,
  output logic [ROW_BITS-1:0] byteIdx,
  output logic                active
);
  localparam int CNT_W = ROW_BITS + 1;
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_BYTES);

  logic [CNT_W-1:0] byteCount;

  // start wins over any strobe or read in the same cycle
  always_comb begin
    strobe.clearAcc = startWr;
    strobe.foldByte = active && nandMode && byteValid && !startWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
    end else if (startWr) begin
      active <= 1'b1;
    end else if (resultRd) begin
      active <= 1'b0;
    end
  end

  // byte position within the block; holds at the limit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCount <= '0;
    end else if (strobe.clearAcc) begin
      byteCount <= '0;
    end else if (strobe.foldByte && byteCount != CNT_LIMIT) begin
      byteCount <= byteCount + 1'b1;
    end
  end

  assign byteIdx = byteCount[ROW_BITS-1:0];
endmodule

// File: rtl/eccDatapath.sv
module eccDatapath
  import eccPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int COL_BITS = 3,
  parameter int ROW_BITS = 9,
  parameter int ECC_W    = 2 * (COL_BITS + ROW_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  eccStrobeT           strobe,
  input  logic [DATA_W-1:0]   byteData,
  input  logic [ROW_BITS-1:0] byteIdx,
  output logic [ECC_W-1:0]    eccResult
);
  logic [COL_BITS-1:0] colEven, colOdd, colEvenIn, colOddIn;
  logic [ROW_BITS-1:0] rowEven, rowOdd;
  logic                bytePar;

  assign bytePar = ^byteData;

  // column contributions of one byte: split bits by one index bit
  always_comb begin
    colEvenIn = '0;
    colOddIn  = '0;
    for (int j = 0; j < COL_BITS; j++) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (((b >> j) & 1) == 1) colOddIn[j]  = colOddIn[j]  ^ byteData[b];
        else                     colEvenIn[j] = colEvenIn[j] ^ byteData[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAcc) begin
      colEven <= '0;
      colOdd  <= '0;
    end else if (strobe.foldByte) begin
      colEven <= colEven ^ colEvenIn;
      colOdd  <= colOdd ^ colOddIn;
    end
  end

  // one even/odd register pair per byte index bit
  for (genvar k = 0; k < ROW_BITS; k++) begin : gRow
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearAcc) begin
        rowEven[k] <= 1'b0;
        rowOdd[k]  <= 1'b0;
      end else if (strobe.foldByte) begin
        if (byteIdx[k]) rowOdd[k]  <= rowOdd[k] ^ bytePar;
        else            rowEven[k] <= rowEven[k] ^ bytePar;
      end
    end
  end

  assign eccResult = {rowOdd, colOdd, rowEven, colEven};
endmodule

// File: rtl/pageEccGen.sv
module pageEccGen
  import eccPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 512,
  parameter int COL_BITS  = $clog2(DATA_W),
  parameter int ROW_BITS  = $clog2(MAX_BYTES),
  parameter int ECC_W     = 2 * (COL_BITS + ROW_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nandMode,
  input  logic              startWr,
  input  logic              resultRd,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  output logic              busy,
  output logic [ECC_W-1:0]  eccResult
);
  eccStrobeT           strobe;
  logic [ROW_BITS-1:0] byteIdx;

  eccCtrl #(.MAX_BYTES(MAX_BYTES), .ROW_BITS(ROW_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .nandMode(nandMode), .startWr(startWr),
    .resultRd(resultRd), .byteValid(byteValid), .strobe(strobe),
    .byteIdx(byteIdx), .active(busy)
  );

  eccDatapath #(.DATA_W(DATA_W), .COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS),
                .ECC_W(ECC_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteData(byteData),
    .byteIdx(byteIdx), .eccResult(eccResult)
  );
endmodule

// File: rtl/pageEccGenChk.sv
module pageEccGenChk #(
  parameter int ECC_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             nandMode,
  input logic             startWr,
  input logic             resultRd,
  input logic             byteValid,
  input logic             busy,
  input logic [ECC_W-1:0] eccResult
);
  localparam int HALF = ECC_W / 2;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    startWr |=> (busy && eccResult == '0)); // R2

  AST_READ_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (resultRd && !startWr) |=> !busy); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startWr) |=> $stable(eccResult)); // R7

  AST_NO_NAND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!nandMode && !startWr) |=> $stable(eccResult)); // R7

  AST_START_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (startWr && (byteValid || resultRd)) |=> (busy && eccResult == '0)); // R8

  for (genvar i = 1; i < HALF; i++) begin : gPair
    AST_PAIR_BALANCE: assert property (@(posedge clk) disable iff (!rstN)
      (eccResult[i] ^ eccResult[i+HALF]) == (eccResult[0] ^ eccResult[HALF])); // R11
  end
endmodule

bind pageEccGen pageEccGenChk #(.ECC_W(ECC_W)) uChk (
  .clk(clk), .rstN(rstN), .nandMode(nandMode), .startWr(startWr),
  .resultRd(resultRd), .byteValid(byteValid), .busy(busy),
  .eccResult(eccResult)
);

// File: tb/pageEccGen_test.sv
module pageEccGen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        nandMode = 1'b1;
  logic        startWr = 1'b0;
  logic        resultRd = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        busy;
  logic [23:0] eccResult;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;
  logic [23:0] expEcc;
  int          expCnt;
  logic [7:0]  lfsr = 8'hA5;

  always #2 clk = ~clk;  // 250 MHz

  pageEccGen uut (
    .clk(clk), .rstN(rstN), .nandMode(nandMode), .startWr(startWr),
    .resultRd(resultRd), .byteValid(byteValid), .byteData(byteData),
    .busy(busy), .eccResult(eccResult)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // model of one folded byte, following R4, R5, R6 and R9
  function automatic logic [23:0] fold(input logic [23:0] e, input logic [7:0] d, input int cnt);
    logic [23:0] r = e;
    int idx = (cnt >= 512) ? 0 : cnt;
    r[0]  ^= ^(d & 8'h55);  r[12] ^= ^(d & 8'hAA);
    r[1]  ^= ^(d & 8'h33);  r[13] ^= ^(d & 8'hCC);
    r[2]  ^= ^(d & 8'h0F);  r[14] ^= ^(d & 8'hF0);
    for (int k = 0; k < 9; k++) begin
      if ((idx >> k) & 1) r[15+k] ^= ^d;
      else                r[3+k]  ^= ^d;
    end
    return r;
  endfunction

  function automatic logic [7:0] nextData();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return lfsr;
  endfunction

  task automatic doStart();
    @(negedge clk); startWr = 1'b1;
    @(negedge clk); startWr = 1'b0;
    expEcc = '0; expCnt = 0;
    check("R2 busy after start", busy, 1);
    check("R2 result cleared", eccResult, 0);
  endtask

  task automatic sendByte(input logic [7:0] d);
    @(negedge clk); byteValid = 1'b1; byteData = d;
    expEcc = fold(expEcc, d, expCnt);
    expCnt++;
    @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic sendBurst(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = nextData();
      @(negedge clk); byteValid = 1'b1; byteData = d;
      expEcc = fold(expEcc, d, expCnt);
      expCnt++;
    end
    @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic doRead();
    @(negedge clk); resultRd = 1'b1;
    @(negedge clk); resultRd = 1'b0;
  endtask

  task automatic tReset();
    check("R1 busy at reset", busy, 0);
    check("R1 result at reset", eccResult, 0);
  endtask

  task automatic tColumns();
    doStart(); sendByte(8'h01);
    check("R4 byte 01 pattern", eccResult, 24'h000FFF);
    doStart(); sendByte(8'h80);
    check("R6 byte 80 pattern", eccResult, 24'h007FF8);
    doStart(); sendByte(8'h3C); sendByte(8'h05);
    check("R4 two bytes", eccResult, expEcc);
  endtask

  task automatic tRows();
    doStart(); sendBurst(100);
    check("R5 100 byte block", eccResult, expEcc);
    check("R11 pair balance", eccResult[11:0] ^ eccResult[23:12],
          {12{eccResult[0] ^ eccResult[12]}});
  endtask

  task automatic tReadAndIgnore();
    logic [23:0] held;
    doStart(); sendBurst(20);
    held = eccResult;
    doRead();
    check("R3 busy cleared by read", busy, 0);
    check("R3 result kept", eccResult, held);
    sendByte(8'hFF); expEcc = held;
    check("R7 byte ignored when idle", eccResult, held);
    doStart(); sendBurst(10);
    held = eccResult;
    nandMode = 1'b0;
    sendByte(8'h01); expEcc = held;
    nandMode = 1'b1;
    check("R7 byte ignored outside NAND", eccResult, held);
    check("R7 still busy", busy, 1);
  endtask

  task automatic tPriority();
    doStart(); sendBurst(5);
    @(negedge clk); startWr = 1'b1; byteValid = 1'b1; byteData = 8'h01; resultRd = 1'b1;
    @(negedge clk); startWr = 1'b0; byteValid = 1'b0; resultRd = 1'b0;
    check("R8 byte dropped on start", eccResult, 0);
    check("R8 read loses to start", busy, 1);
  endtask

  task automatic tSmallBlocks();
    doStart(); sendBurst(256);
    check("R10 256 bytes full", eccResult, expEcc);
    check("R10 odd pair 8 zero", eccResult[23], 0);
    doStart(); sendBurst(128);
    check("R10 128 bytes pairs 7,8 zero", eccResult[23:22], 0);
  endtask

  task automatic tOverflow();
    doStart(); sendBurst(512);
    check("R5 full 512 bytes", eccResult, expEcc);
    sendBurst(9);
    check("R9 bytes past limit", eccResult, expEcc);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tColumns();
    tRows();
    tReadAndIgnore();
    tPriority();
    tSmallBlocks();
    tOverflow();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule